// File: doc/BRIEF.md
# Command-Strobe Interval Timer

A single interval timer channel with a 32-bit up-counter, run through a small register window on a simple synchronous bus (address, write strobe, write data, read strobe, read data). Starting, stopping and clearing the channel are not control bits. Each of these actions has its own command address, and a write of any data value to that address performs the action. The counter moves forward only on cycles where an external tick-enable input is high, so a prescaler outside the block sets the time base.

The channel compares its count with a programmable terminal value. In continuous mode it returns to zero at each terminal event and keeps producing events. With a terminal value of all ones it acts as a free-running counter that wraps. In one-shot mode it holds the count at the terminal value and stops. Each terminal event sets a pending flag. The level interrupt output is that flag gated by an interrupt-enable bit. Software clears the flag by writing the acknowledge register. A packed status word reports a 4-bit state code, the enabled flag, the mode, the interrupt-enable bit and the pending flag.

Top module: `cmd_interval_timer`

## Requirements
- R1: After reset the count reads 0, the terminal value reads 0xFFFFFFFF, status (offset 0x10) reads 0x01, and irq is low.
- R2: A write of any data to offset 0x04 enables the channel and a write to 0x08 disables it. Status bits 3:0 read 2 while enabled and 1 while disabled, and status bit 4 is the enabled flag.
- R3: The count at offset 0x14 goes up by exactly one on each clock edge where tick_en is high and the channel is enabled. At every other edge it stays unchanged.
- R4: In continuous mode (mode register 0x0C bit 0 = 0), a counting edge at which the count equals the terminal value (offset 0x18) returns the count to 0 and sets pending (status bit 7). A terminal value of 0 therefore gives an event on every tick.
- R5: In one-shot mode (mode bit 0 = 1, shown in status bit 5), the terminal event sets pending, holds the count at the terminal value, clears the enabled flag and returns the state code to 1.
- R6: Pending latches on a terminal event even while the interrupt is disabled. irq is high exactly when pending is set and interrupt-enable (offset 0x1C bit 0, shown in status bit 6) is 1.
- R7: A write to offset 0x20 with data bit 7 set clears pending. The same write with bit 7 clear leaves pending unchanged. If a terminal event happens in the same cycle as a clearing write, pending stays set.
- R8: A write of any data to offset 0x00 clears the count and pending. It leaves the terminal value, mode, interrupt-enable and enabled flag unchanged.
- R9: Reads of offsets 0x00, 0x04, 0x08, 0x20 and of any unmapped or misaligned address return 0. Writes to status (0x10) and count (0x14) have no effect.
- R10: bus_rdata takes the selected register's value at the clock edge where bus_rd is high and holds that value while bus_rd is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_en | input | 1 | Count-advance qualifier |
| bus_addr | input | ADDR_W (8) | Byte address of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | DATA_W (32) | Registered read data |
| irq | output | 1 | Level interrupt, pending AND interrupt-enable |

## Verification
A register write takes effect at the clock edge that samples the strobe. The status, count, pending flag and irq can therefore be observed half a cycle later. A read returns, one edge after its strobe, the value the register held before that edge. Counting scenarios drive tick_en for an exact number of edges, from one falling edge to another, and sample only after tick_en has dropped, so the expected count is simply that number of edges folded by the terminal rule. The same-cycle acknowledge case raises tick_en and the acknowledge strobe within a single low clock phase, so both are seen by the same edge.

// File: rtl/itmr_pkg.sv
package itmr_pkg;

  // Byte offsets of the register window
  localparam int OFS_CLR   = 'h00;
  localparam int OFS_GO    = 'h04;
  localparam int OFS_HALT  = 'h08;
  localparam int OFS_MODE  = 'h0C;
  localparam int OFS_STAT  = 'h10;
  localparam int OFS_CNT   = 'h14;
  localparam int OFS_TERM  = 'h18;
  localparam int OFS_IEN   = 'h1C;
  localparam int OFS_ACK   = 'h20;

  localparam int ACK_BIT   = 7;

  typedef enum logic [3:0] {
    ST_IDLE   = 4'd1,
    ST_ACTIVE = 4'd2
  } itmr_state_e;

  // One address-match flag per register
  typedef struct packed {
    logic clr;
    logic go;
    logic halt;
    logic mode;
    logic stat;
    logic cnt;
    logic term;
    logic ien;
    logic ack;
  } itmr_sel_t;

  function automatic logic [7:0] pack_status(input logic en, input logic one_shot,
                                             input logic ien, input logic pend);
    itmr_state_e st;
    st = en ? ST_ACTIVE : ST_IDLE;
    return {pend, ien, one_shot, en, st};
  endfunction

endpackage

// File: rtl/itmr_decode.sv
module itmr_decode
  import itmr_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output itmr_sel_t         sel
);

  function automatic logic at(input logic [ADDR_W-1:0] a, input int ofs);
    return a == ADDR_W'(ofs);
  endfunction

  always_comb begin
    sel.clr  = at(addr, OFS_CLR);
    sel.go   = at(addr, OFS_GO);
    sel.halt = at(addr, OFS_HALT);
    sel.mode = at(addr, OFS_MODE);
    sel.stat = at(addr, OFS_STAT);
    sel.cnt  = at(addr, OFS_CNT);
    sel.term = at(addr, OFS_TERM);
    sel.ien  = at(addr, OFS_IEN);
    sel.ack  = at(addr, OFS_ACK);
  end

endmodule

// File: rtl/itmr_counter.sv
module itmr_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             cmd_clr,
  input  logic             cmd_go,
  input  logic             cmd_halt,
  input  logic             one_shot,
  input  logic [CNT_W-1:0] terminal,
  output logic [CNT_W-1:0] count,
  output logic             enabled,
  output logic             term_hit
);

  logic advance;

  function automatic logic [CNT_W-1:0] after_hit(input logic [CNT_W-1:0] c, input logic os);
    return os ? c : '0;
  endfunction

  assign advance  = enabled && tick_en && !cmd_clr;
  assign term_hit = advance && (count == terminal);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count   <= '0;
      enabled <= 1'b0;
    end else begin
      if (cmd_clr)       count <= '0;
      else if (term_hit) count <= after_hit(count, one_shot);
      else if (advance)  count <= count + 1'b1;

      if (cmd_go)                    enabled <= 1'b1;
      else if (cmd_halt)             enabled <= 1'b0;
      else if (term_hit && one_shot) enabled <= 1'b0;
    end
  end

  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!(enabled && tick_en) && !cmd_clr) |=> $stable(count));
  a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !term_hit) |=> count == CNT_W'($past(count) + 1'b1));
  a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (term_hit && !one_shot) |=> count == '0);
  a_r5_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (term_hit && one_shot && !cmd_go) |=> (!enabled && $stable(count)));
  a_r8_zero: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_clr |=> count == '0);

endmodule

// File: rtl/itmr_pending.sv
module itmr_pending (
  input  logic clk,
  input  logic rst_n,
  input  logic term_hit,
  input  logic cmd_clr,
  input  logic ack_wr,
  output logic pending
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pending <= 1'b0;
    else if (cmd_clr)  pending <= 1'b0;
    else if (term_hit) pending <= 1'b1;
    else if (ack_wr)   pending <= 1'b0;
  end

  a_r6_latch: assert property (@(posedge clk) disable iff (!rst_n)
    term_hit |=> pending);
  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_wr && !term_hit) |=> !pending);
  a_r7_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !ack_wr && !cmd_clr) |=> pending);
  a_r8_drop: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_clr |=> !pending);

endmodule

// File: rtl/cmd_interval_timer.sv
module cmd_interval_timer
  import itmr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);

  itmr_sel_t        sel;
  logic             one_shot_q;
  logic             ien_q;
  logic [CNT_W-1:0] term_q;
  logic [CNT_W-1:0] count;
  logic             enabled;
  logic             term_hit;
  logic             pending;
  logic             ack_wr;
  logic [DATA_W-1:0] rd_mux;

  itmr_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr (bus_addr),
    .sel  (sel)
  );

  itmr_counter #(.CNT_W(CNT_W)) u_counter (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick_en),
    .cmd_clr  (bus_wr && sel.clr),
    .cmd_go   (bus_wr && sel.go),
    .cmd_halt (bus_wr && sel.halt),
    .one_shot (one_shot_q),
    .terminal (term_q),
    .count    (count),
    .enabled  (enabled),
    .term_hit (term_hit)
  );

  assign ack_wr = bus_wr && sel.ack && bus_wdata[ACK_BIT];

  itmr_pending u_pending (
    .clk      (clk),
    .rst_n    (rst_n),
    .term_hit (term_hit),
    .cmd_clr  (bus_wr && sel.clr),
    .ack_wr   (ack_wr),
    .pending  (pending)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      one_shot_q <= 1'b0;
      ien_q      <= 1'b0;
      term_q     <= '1;
    end else if (bus_wr) begin
      if (sel.mode) one_shot_q <= bus_wdata[0];
      if (sel.ien)  ien_q      <= bus_wdata[0];
      if (sel.term) term_q     <= bus_wdata[CNT_W-1:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    if (sel.mode) rd_mux = DATA_W'(one_shot_q);
    if (sel.ien)  rd_mux = DATA_W'(ien_q);
    if (sel.term) rd_mux = DATA_W'(term_q);
    if (sel.cnt)  rd_mux = DATA_W'(count);
    if (sel.stat) rd_mux = DATA_W'(pack_status(enabled, one_shot_q, ien_q, pending));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  assign irq = pending && ien_q;

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));
  a_r6_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (!ien_q && !(bus_wr && sel.ien)) |=> !irq);
  a_r8_keep_term: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && sel.clr) |=> $stable(term_q));

endmodule

// File: tb/cmd_interval_timer_tb.sv
module cmd_interval_timer_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cmd_interval_timer u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .irq       (irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (n) @(posedge clk);
    @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic chk_rd(input string tag, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic t_reset_state;
    chk_rd("R1 status", 8'h10, 32'h01);
    chk_rd("R1 count", 8'h14, 32'h0);
    chk_rd("R1 terminal", 8'h18, 32'hFFFF_FFFF);
    chk("R1 irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_enable_count;
    wr(8'h04, 32'hDEAD_BEEF);
    chk_rd("R2 active status", 8'h10, 32'h12);
    ticks(5);
    chk_rd("R3 five ticks", 8'h14, 32'd5);
    repeat (3) @(negedge clk);
    chk_rd("R3 no tick no count", 8'h14, 32'd5);
    wr(8'h08, 32'h0);
    chk_rd("R2 idle status", 8'h10, 32'h01);
    ticks(3);
    chk_rd("R3 disabled holds", 8'h14, 32'd5);
  endtask

  task automatic t_continuous;
    wr(8'h00, 32'h1);
    wr(8'h18, 32'd3);
    wr(8'h04, 32'h0);
    ticks(4);
    chk_rd("R4 wrap to zero", 8'h14, 32'd0);
    chk_rd("R6 pending while masked", 8'h10, 32'h92);
    chk("R6 irq masked", {31'b0, irq}, 32'h0);
    ticks(2);
    chk_rd("R4 keeps running", 8'h14, 32'd2);
    wr(8'h1C, 32'h1);
    chk("R6 irq on enable", {31'b0, irq}, 32'h1);
    chk_rd("R6 status ien", 8'h10, 32'hD2);
    wr(8'h20, 32'h7F);
    chk_rd("R7 ack without bit7", 8'h10, 32'hD2);
    wr(8'h20, 32'h80);
    chk_rd("R7 ack clears", 8'h10, 32'h52);
    chk("R7 irq low", {31'b0, irq}, 32'h0);
    ticks(2);
    chk_rd("R4 second wrap", 8'h14, 32'd0);
    chk("R6 irq second event", {31'b0, irq}, 32'h1);
    wr(8'h08, 32'h0);
    wr(8'h00, 32'h0);
    wr(8'h18, 32'd0);
    wr(8'h1C, 32'h0);
    wr(8'h04, 32'h0);
    ticks(1);
    chk_rd("R4 terminal zero", 8'h10, 32'h92);
    chk_rd("R4 terminal zero count", 8'h14, 32'd0);
  endtask

  task automatic t_ack_race;
    @(negedge clk);
    tick_en = 1'b1; bus_addr = 8'h20; bus_wdata = 32'h80; bus_wr = 1'b1;
    @(negedge clk);
    tick_en = 1'b0; bus_wr = 1'b0;
    chk_rd("R7 event beats ack", 8'h10, 32'h92);
    wr(8'h20, 32'hFFFF_FFFF);
    chk_rd("R7 plain ack", 8'h10, 32'h12);
  endtask

  task automatic t_one_shot;
    wr(8'h08, 32'h0);
    wr(8'h00, 32'h0);
    wr(8'h0C, 32'h1);
    wr(8'h18, 32'd2);
    wr(8'h04, 32'h0);
    chk_rd("R5 mode bit", 8'h10, 32'h32);
    ticks(5);
    chk_rd("R5 count holds", 8'h14, 32'd2);
    chk_rd("R5 stopped idle", 8'h10, 32'hA1);
  endtask

  task automatic t_clear_cmd;
    wr(8'h1C, 32'h1);
    wr(8'h18, 32'd7);
    wr(8'h0C, 32'h0);
    wr(8'h04, 32'h0);
    ticks(3);
    chk_rd("R3 resume count", 8'h14, 32'd5);
    wr(8'h00, 32'h5A5A);
    chk_rd("R8 count cleared", 8'h14, 32'd0);
    chk_rd("R8 status kept", 8'h10, 32'h52);
    chk_rd("R8 terminal kept", 8'h18, 32'd7);
    chk("R8 irq low", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_unmapped;
    chk_rd("R9 read clr", 8'h00, 32'h0);
    chk_rd("R9 read go", 8'h04, 32'h0);
    chk_rd("R9 read halt", 8'h08, 32'h0);
    chk_rd("R9 read ack", 8'h20, 32'h0);
    chk_rd("R9 read unmapped", 8'h3C, 32'h0);
    chk_rd("R9 read misaligned", 8'h15, 32'h0);
    wr(8'h10, 32'hFFFF_FFFF);
    wr(8'h14, 32'h1234);
    chk_rd("R9 status write ignored", 8'h10, 32'h52);
    chk_rd("R9 count write ignored", 8'h14, 32'h0);
  endtask

  task automatic t_read_hold;
    logic [31:0] v;
    rd(8'h14, v);
    ticks(4);
    chk("R10 rdata holds", bus_rdata, 32'h0);
    chk_rd("R10 fresh read", 8'h14, 32'd4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_state;
    t_enable_count;
    t_continuous;
    t_ack_race;
    t_one_shot;
    t_clear_cmd;
    t_unmapped;
    t_read_hold;
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule